// File: doc/BRIEF.md
# Decimal-mode add/subtract unit

An 8-bit arithmetic unit that adds or subtracts two operand bytes with a carry input. It runs in plain two's-complement mode or in decimal mode. In decimal mode it applies the nibble corrections of a CMOS 8-bit processor ALU exactly as that ALU does, including the odd results it gives when a nibble holds 0xA to 0xF. The flags come from two places. N and Z always describe the byte that is delivered. In decimal mode V is taken from an intermediate or a binary computation, and for subtraction C is too, not from the corrected byte.

The arithmetic is purely combinational. A parameter selects whether the result is delivered directly or through one register stage:

- **Registered variant (default):** the stage has a valid input and a valid output. A cycle without valid input holds the last delivered result.
- **Direct variant:** the result appears in the same cycle, and valid passes straight through.

Instruction decode and storage of the status bits belong to the surrounding processor.

Top module: `dec_arith_unit`

## Requirements
- R1: With dec_en=0 and do_sub=0, res = (opa + opb + cin) mod 256. flag_c is bit 8 of that sum. flag_v=1 when opa and opb have equal bit 7 and res bit 7 differs from it.
- R2: With dec_en=0 and do_sub=1, res = (opa + ~opb + cin) mod 256, so cin=1 means no borrow. flag_c=1 when opa >= opb + (1-cin). flag_v=1 when opa and opb differ in bit 7 and res bit 7 differs from opa bit 7.
- R3: Decimal add, low part: s = opa[3:0] + opb[3:0] + cin. If s >= 10, the kept low nibble is (s+6) mod 16 and 0x10 is carried into the upper add. Otherwise the kept low nibble is s.
- R4: Decimal add, upper part: m = {opa[7:4], kept nibble} + {opb[7:4], 0} + nibble carry. If m >= 0xA0 (a carry out included), res = (m+0x60) mod 256 and flag_c=1. Otherwise res = m and flag_c=0.
- R5: Decimal add: flag_v is the signed overflow of the addition that produces m. This is tested on bit 7 of opa, opb and m, before the 0x60 correction.
- R6: Decimal subtract: d = opa[3:0] - opb[3:0] - (1-cin). A borrow occurs when d < 0. The upper part is t = {opa[7:4], d mod 16} - {opb[7:4], 0} - (0x10 if low borrow). If t < 0, subtract a further 0x60. Then, if the low part borrowed, subtract 6. res is the final value mod 256.
- R7: Decimal subtract: flag_v and flag_c equal the values the binary subtraction of R2 gives for the same opa, opb and cin.
- R8: In every mode flag_n = res[7] and flag_z = (res == 0).
- R9: Every opa, opb and cin value gives the result defined by R1 to R8, non-decimal nibbles included.
- R10: With REG_OUT=1, inputs presented with in_vld=1 appear on res and the flags after the next rising clock edge, with out_vld=1.
- R11: With REG_OUT=1, a cycle with in_vld=0 leaves res and the flags unchanged and clears out_vld after that edge, whatever the other inputs carry.
- R12: While rst_n=0, out_vld, res and all four flags are 0, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_vld | input | 1 | Operands valid this cycle |
| opa | input | 8 | First operand (minuend for subtract) |
| opb | input | 8 | Second operand (subtrahend for subtract) |
| cin | input | 1 | Carry in; for subtract 1 means no borrow |
| dec_en | input | 1 | 1 selects decimal correction |
| do_sub | input | 1 | 1 selects subtract, 0 add |
| out_vld | output | 1 | Result valid |
| res | output | 8 | Result byte |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / not-borrow flag |

## Verification
Both decimal corrections can act in the same operation:

- **Add:** the low-nibble +6 with its carry, then the +0x60 upper correction.
- **Subtract:** the -0x60 for an upper borrow, then the trailing -6 for a low borrow.

A hand-computed vector table provokes these pairs with operands such as 0x99+0x01, 0xFF+0xFF, 0x00-0x01 and 0x0A-0x0F, where the second correction depends on what the first did. Exhaustive decimal sweeps of both operands are then judged against an integer model in the bench, written from R3 to R7. Those sweeps also cover the cases where V or C must come from the binary path while N and Z follow the corrected byte.

// File: rtl/dau_pkg.sv
package dau_pkg;
  localparam int DW = 8;
  localparam int NW = DW / 2;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } dau_flags_t;
endpackage

// File: rtl/dau_bin_core.sv
module dau_bin_core
  import dau_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          sub,
  output logic [DW-1:0] y,
  output logic          v,
  output logic          c
);
  logic [DW-1:0] b_eff;
  logic [DW:0]   total;

  always_comb begin
    b_eff = sub ? ~b : b;
    total = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, cin};
    y     = total[DW-1:0];
    c     = total[DW];
    v     = (a[DW-1] == b_eff[DW-1]) && (total[DW-1] != a[DW-1]);
  end
endmodule

// File: rtl/dau_dec_add.sv
module dau_dec_add
  import dau_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] y,
  output logic          v,
  output logic          c
);
  localparam logic [NW:0] LO_LIMIT = (NW+1)'(10);
  localparam logic [NW-1:0] LO_FIX = NW'(6);
  localparam logic [DW:0] HI_LIMIT = (DW+1)'(8'hA0);
  localparam logic [DW-1:0] HI_FIX = DW'(8'h60);

  logic [NW:0]   lo_sum;
  logic          lo_carry;
  logic [NW-1:0] lo_keep;
  logic [DW:0]   mid;
  logic          hi_fix;

  always_comb begin
    lo_sum   = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin};
    lo_carry = (lo_sum >= LO_LIMIT);
    lo_keep  = lo_carry ? (lo_sum[NW-1:0] + LO_FIX) : lo_sum[NW-1:0];
    mid      = {1'b0, a[DW-1:NW], lo_keep}
             + {1'b0, b[DW-1:NW], {NW{1'b0}}}
             + {{(DW-NW){1'b0}}, lo_carry, {NW{1'b0}}};
    v        = (a[DW-1] == b[DW-1]) && (mid[DW-1] != a[DW-1]);
    hi_fix   = (mid >= HI_LIMIT);
    y        = hi_fix ? (mid[DW-1:0] + HI_FIX) : mid[DW-1:0];
    c        = hi_fix;
  end
endmodule

// File: rtl/dau_dec_sub.sv
module dau_dec_sub
  import dau_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] y
);
  localparam logic [DW-1:0] HI_FIX = DW'(8'h60);
  localparam logic [DW-1:0] LO_FIX = DW'(6);

  logic [NW:0]   lo_dif;
  logic          lo_borrow;
  logic [DW:0]   mid;
  logic [DW-1:0] step1;

  always_comb begin
    lo_dif    = {1'b0, a[NW-1:0]} - {1'b0, b[NW-1:0]} - {{NW{1'b0}}, ~cin};
    lo_borrow = lo_dif[NW];
    mid       = {1'b0, a[DW-1:NW], lo_dif[NW-1:0]}
              - {1'b0, b[DW-1:NW], {NW{1'b0}}}
              - {{(DW-NW){1'b0}}, lo_borrow, {NW{1'b0}}};
    step1     = mid[DW] ? (mid[DW-1:0] - HI_FIX) : mid[DW-1:0];
    y         = lo_borrow ? (step1 - LO_FIX) : step1;
  end
endmodule

// File: rtl/dau_out_stage.sv
module dau_out_stage
  import dau_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          d_vld,
  input  logic [DW-1:0] d_res,
  input  dau_flags_t    d_flg,
  output logic          q_vld,
  output logic [DW-1:0] q_res,
  output dau_flags_t    q_flg
);
  generate
    if (REG_OUT) begin : g_reg
      logic          vld_q, vld_d;
      logic [DW-1:0] res_q, res_d;
      dau_flags_t    flg_q, flg_d;

      always_comb begin
        vld_d = d_vld;
        res_d = res_q;
        flg_d = flg_q;
        if (d_vld) begin
          res_d = d_res;
          flg_d = d_flg;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          res_q <= '0;
          flg_q <= '0;
        end else begin
          vld_q <= vld_d;
          res_q <= res_d;
          flg_q <= flg_d;
        end
      end

      assign q_vld = vld_q;
      assign q_res = res_q;
      assign q_flg = flg_q;
    end else begin : g_comb
      assign q_vld = d_vld & rst_n;
      assign q_res = rst_n ? d_res : '0;
      assign q_flg = rst_n ? d_flg : '0;
    end
  endgenerate
endmodule

// File: rtl/dec_arith_unit.sv
module dec_arith_unit
  import dau_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic          cin,
  input  logic          dec_en,
  input  logic          do_sub,
  output logic          out_vld,
  output logic [DW-1:0] res,
  output logic          flag_n,
  output logic          flag_v,
  output logic          flag_z,
  output logic          flag_c
);
  logic [DW-1:0] bin_y, da_y, ds_y, sel_y;
  logic          bin_v, bin_c, da_v, da_c;
  dau_flags_t    sel_f, out_f;

  dau_bin_core u_bin (
    .a(opa), .b(opb), .cin(cin), .sub(do_sub),
    .y(bin_y), .v(bin_v), .c(bin_c)
  );

  dau_dec_add u_dadd (
    .a(opa), .b(opb), .cin(cin),
    .y(da_y), .v(da_v), .c(da_c)
  );

  dau_dec_sub u_dsub (
    .a(opa), .b(opb), .cin(cin),
    .y(ds_y)
  );

  always_comb begin
    if (!dec_en)     sel_y = bin_y;
    else if (do_sub) sel_y = ds_y;
    else             sel_y = da_y;
    sel_f.n = sel_y[DW-1];
    sel_f.z = ~|sel_y;
    sel_f.v = (dec_en && !do_sub) ? da_v : bin_v;
    sel_f.c = (dec_en && !do_sub) ? da_c : bin_c;
  end

  dau_out_stage #(.REG_OUT(REG_OUT)) u_out (
    .clk(clk), .rst_n(rst_n),
    .d_vld(in_vld), .d_res(sel_y), .d_flg(sel_f),
    .q_vld(out_vld), .q_res(res), .q_flg(out_f)
  );

  assign flag_n = out_f.n;
  assign flag_v = out_f.v;
  assign flag_z = out_f.z;
  assign flag_c = out_f.c;
endmodule

// File: rtl/dau_checker.sv
module dau_checker
  import dau_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_vld,
  input logic [DW-1:0] opa,
  input logic [DW-1:0] opb,
  input logic          cin,
  input logic          dec_en,
  input logic          do_sub,
  input logic          out_vld,
  input logic [DW-1:0] res,
  input logic          flag_n,
  input logic          flag_v,
  input logic          flag_z,
  input logic          flag_c
);
  generate
    if (REG_OUT) begin : g_chk
      // R10
      valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);

      // R11
      idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> (!out_vld && $stable(res) && $stable(flag_n) && $stable(flag_v)
                     && $stable(flag_z) && $stable(flag_c)));

      // R8
      zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (flag_z == (res == '0)));

      // R8
      neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (flag_n == res[DW-1]));

      // R1
      bin_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !dec_en && !do_sub) |=>
          (res == DW'($past(opa) + $past(opb) + {{(DW-1){1'b0}}, $past(cin)})));

      // R7
      sub_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && do_sub) |=>
          (flag_c == ({1'b0, $past(opa)} >= ({1'b0, $past(opb)} + {{DW{1'b0}}, !$past(cin)}))));
    end else begin : g_chk_comb
      // R8
      always_comb begin
        if (rst_n && out_vld) begin
          comb_zero_flag_chk: assert (flag_z == (res == '0));
        end
      end
    end
  endgenerate
endmodule

bind dec_arith_unit dau_checker #(.REG_OUT(REG_OUT)) u_dau_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .opa(opa), .opb(opb), .cin(cin),
  .dec_en(dec_en), .do_sub(do_sub), .out_vld(out_vld), .res(res),
  .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c)
);

// File: tb/tb_dec_arith_unit.sv
module tb_dec_arith_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_vld;
  logic [7:0] opa, opb;
  logic       cin, dec_en, do_sub;
  logic       out_vld;
  logic [7:0] res;
  logic       flag_n, flag_v, flag_z, flag_c;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dec_arith_unit #(.REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .opa(opa), .opb(opb), .cin(cin),
    .dec_en(dec_en), .do_sub(do_sub), .out_vld(out_vld), .res(res),
    .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c)
  );

  // {do_sub, dec_en, cin, opa, opb, res, n, v, z, c}
  localparam int NVEC = 16;
  localparam logic [30:0] VEC [NVEC] = '{
    {3'b010, 8'h99, 8'h01, 8'h00, 4'b0011},
    {3'b011, 8'h58, 8'h46, 8'h05, 4'b0101},
    {3'b010, 8'h12, 8'h34, 8'h46, 4'b0000},
    {3'b010, 8'h0F, 8'h0F, 8'h14, 4'b0000},
    {3'b011, 8'hFF, 8'hFF, 8'h55, 4'b0001},
    {3'b011, 8'h79, 8'h00, 8'h80, 4'b1100},
    {3'b111, 8'h00, 8'h01, 8'h99, 4'b1000},
    {3'b111, 8'h10, 8'h01, 8'h09, 4'b0001},
    {3'b111, 8'h50, 8'h50, 8'h00, 4'b0011},
    {3'b110, 8'h46, 8'h12, 8'h33, 4'b0001},
    {3'b111, 8'h80, 8'h01, 8'h79, 4'b0101},
    {3'b111, 8'h0A, 8'h0F, 8'h95, 4'b1000},
    {3'b000, 8'h7F, 8'h01, 8'h80, 4'b1100},
    {3'b000, 8'hFF, 8'h01, 8'h00, 4'b0011},
    {3'b101, 8'h80, 8'h01, 8'h7F, 4'b0101},
    {3'b100, 8'h00, 8'h00, 8'hFF, 4'b1000}
  };

  function automatic logic [11:0] model(input int a, input int b, input int ci,
                                        input bit dec, input bit sub);
    int y, t, lo, bin;
    bit c, v, lb;
    if (!sub) begin
      if (!dec) begin
        bin = a + b + ci;
        y = bin & 255;
        c = (bin > 255);
        v = (((a ^ y) & (b ^ y) & 128) != 0);
      end else begin
        lo = (a % 16) + (b % 16) + ci;
        t = (a / 16) * 16 + (b / 16) * 16;
        if (lo >= 10) t = t + ((lo + 6) % 16) + 16;
        else          t = t + lo;
        v = (((a ^ t) & (b ^ t) & 128) != 0);
        c = (t >= 160);
        if (c) t = t + 96;
        y = t & 255;
      end
    end else begin
      bin = a - b - (1 - ci);
      c = (bin >= 0);
      v = (((a ^ b) & (a ^ (bin & 255)) & 128) != 0);
      if (!dec) y = bin & 255;
      else begin
        lo = (a % 16) - (b % 16) - (1 - ci);
        lb = (lo < 0);
        t = (a / 16) * 16 + (lo & 15) - (b / 16) * 16 - (lb ? 16 : 0);
        if (t < 0) t = t - 96;
        if (lb) t = t - 6;
        y = t & 255;
      end
    end
    return {8'(y), y[7], v, (y == 0), c};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input bit s, input bit d, input bit c, input logic [7:0] a,
                       input logic [7:0] b);
    in_vld = 1'b1; do_sub = s; dec_en = d; cin = c; opa = a; opb = b;
  endtask

  function automatic string vec_tag(input bit s, input bit d);
    if (d && s)  return "R6 R7 R8 dec-sub";
    if (d)       return "R3 R4 R5 R8 dec-add";
    if (s)       return "R2 R8 bin-sub";
    return "R1 R8 bin-add";
  endfunction

  initial begin
    rst_n = 1'b0; in_vld = 1'b0; opa = '0; opb = '0; cin = 1'b0;
    dec_en = 1'b0; do_sub = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 reset", {out_vld, res, flag_n, flag_v, flag_z, flag_c}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table, one cycle per vector (R10: out_vld high)
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][30], VEC[i][29], VEC[i][28], VEC[i][27:20], VEC[i][19:12]);
      @(negedge clk);
      check(vec_tag(VEC[i][30], VEC[i][29]),
            {res, flag_n, flag_v, flag_z, flag_c}, VEC[i][11:0]);
      check("R10 out_vld", {31'd0, out_vld}, 32'd1);
    end

    // R11: idle cycle with changed operands keeps last result
    drive(1'b0, 1'b1, 1'b0, 8'h12, 8'h34);
    @(negedge clk);
    in_vld = 1'b0; opa = 8'hFF; opb = 8'hFF; cin = 1'b1; do_sub = 1'b1;
    @(negedge clk);
    check("R11 hold", {out_vld, res, flag_n, flag_v, flag_z, flag_c},
          {1'b0, 8'h46, 4'b0000});

    // R9 exhaustive decimal sweeps (cin alternates with operand parity)
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          automatic bit ci = bit'((a ^ b ^ s) & 1);
          drive(bit'(s), 1'b1, ci, 8'(a), 8'(b));
          @(negedge clk);
          check(s ? "R9 R6 R7 dec-sub sweep" : "R9 R3 R4 R5 dec-add sweep",
                {res, flag_n, flag_v, flag_z, flag_c}, model(a, b, ci, 1'b1, bit'(s)));
        end
      end
    end

    // R1 R2 strided binary sweeps
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b += 17) begin
          automatic bit ci = bit'((a + b) & 1);
          drive(bit'(s), 1'b0, ci, 8'(a), 8'(b));
          @(negedge clk);
          check(s ? "R2 bin-sub sweep" : "R1 bin-add sweep",
                {res, flag_n, flag_v, flag_z, flag_c}, model(a, b, ci, 1'b0, bit'(s)));
        end
      end
    end

    // R12 asynchronous clear mid-cycle
    drive(1'b0, 1'b0, 1'b0, 8'h7F, 8'h01);
    @(negedge clk);
    in_vld = 1'b0;
    #3 rst_n = 1'b0;
    #2;
    check("R12 async clear", {out_vld, res, flag_n, flag_v, flag_z, flag_c}, '0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule